// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Slave

This block is the device-side end of a three-wire serial link through which a host controller reads and writes a small bank of 8-bit registers. The host drives a serial clock and an active-low select. It shares one bidirectional data wire with the slave. At the block boundary that wire appears as an input, an output and an output enable, so that a pad outside the block can form the tri-state driver.

A transaction lasts sixteen serial clocks. The host first sends a register index and a direction flag. Three idle clocks follow, which give the slave time to decode and give the wire time to change hands. The last eight clocks carry the data byte: the host sends it on a write, and the slave returns it on a read.

The core runs on a fast system clock and samples the serial signals through synchronisers. A second write port and a second registered read port let the rest of the device see and update the same registers.

Top module: `tw_serial_regs`

## Requirements
- R1: After a synchronous reset, `sdio_oe_o`, `sdio_o` and `dev_rdata_o` are all 0.
- R2: A frame starts when `sel_n_i` falls. Data on the wire is taken on rising `sck_i` edges, most significant bit first. Serial clocks 1 to 4 carry the 4-bit register index, and a write reaches only the register at that index.
- R3: Serial clock 5 carries the direction: 1 selects a read and 0 selects a write. A read frame leaves the register contents unchanged.
- R4: Serial clocks 6, 7 and 8 form a gap. The slave does not drive the wire during the gap, and wire values seen during the gap never reach the written data.
- R5: On a write, serial clocks 9 to 16 carry the data byte, most significant bit first. The byte is stored only after the 16th rising edge has been sampled.
- R6: On a read, the slave changes `sdio_o` on falling `sck_i` edges so that the byte, most significant bit first, is valid at rising edges 9 to 16. `sdio_oe_o` is 1 only in that window: it rises after the falling edge that follows clock 8 and falls after the falling edge that follows clock 16.
- R7: If `sel_n_i` rises before the 16th rising edge, the frame is abandoned: no register changes and the output enable goes to 0.
- R8: Serial clocks after the 16th are ignored while select stays low. They cause no further write, and the wire is not driven.
- R9: A device-side write (`dev_we_i`) stores `dev_wdata_i` at `dev_waddr_i`. `dev_rdata_o` shows the register at `dev_raddr_i` one system clock after the address is applied.
- R10: A bus read returns the value last stored by either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the host |
| sel_n_i | input | 1 | Active-low frame select from the host |
| sdio_i | input | 1 | Value present on the shared data wire |
| sdio_o | output | 1 | Value the slave drives onto the data wire |
| sdio_oe_o | output | 1 | Output enable for the data wire driver |
| dev_we_i | input | 1 | Device-side write strobe |
| dev_waddr_i | input | 4 | Device-side write index |
| dev_wdata_i | input | 8 | Device-side write data |
| dev_raddr_i | input | 4 | Device-side read index |
| dev_rdata_o | output | 8 | Registered device-side read data |

## Verification
`dev_rdata_o` follows the read index after one system clock. The bench therefore applies the index on a falling system clock edge and compares the result on the next falling edge. A serial write lands within six system clocks of the 16th rising edge, and the bench reads it back only after the closing half-period, the deselect and a further twelve cycles. Read bits change about three system clocks after each falling serial edge. The monitor samples the wire and the enable on the next rising serial edge, four system clocks later, and pops the expected byte from the scoreboard once the 16th edge has been seen.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_DONE  = 2'd2
  } tw_phase_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_waddr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_waddr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic [ADDR_W-1:0] ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [ADDR_W-1:0] rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;

  // The serial side takes priority when both ports write in the same cycle.
  always_comb begin
    we    = a_we_i | b_we_i;
    waddr = a_we_i ? a_waddr_i : b_waddr_i;
    wdata = a_we_i ? a_wdata_i : b_wdata_i;
  end

  // The array has no reset, so it can map onto block or distributed RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_data_o <= '0;
      rb_data_o <= '0;
    end else begin
      ra_data_o <= mem[ra_addr_i];
      rb_data_o <= mem[rb_addr_i];
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata))); // R9
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int GAP_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s_i,
  input  logic              sel_n_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int FRAME = ADDR_W + 1 + GAP_CLKS + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] C_ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] C_DIR       = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_LOAD      = CNT_W'(ADDR_W + GAP_CLKS);
  localparam logic [CNT_W-1:0] C_DRV_LO    = CNT_W'(ADDR_W + GAP_CLKS + 1);
  localparam logic [CNT_W-1:0] C_LAST      = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] C_FRAME     = CNT_W'(FRAME);

  tw_phase_e         phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] out_sh_q;
  logic              is_read_q;
  logic              sck_d_q;
  logic              sel_d_q;
  logic              sck_rise;
  logic              sck_fall;
  logic              sel_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d_q <= 1'b0;
      sel_d_q <= 1'b1;
    end else begin
      sck_d_q <= sck_s_i;
      sel_d_q <= sel_n_s_i;
    end
  end

  assign sck_rise = sck_s_i & ~sck_d_q;
  assign sck_fall = ~sck_s_i & sck_d_q;
  assign sel_fall = ~sel_n_s_i & sel_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      out_sh_q  <= '0;
      is_read_q <= 1'b0;
      addr_o    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      sdo_o     <= 1'b0;
      sdo_oe_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (sel_n_s_i) begin
        phase_q  <= PH_IDLE;
        sdo_oe_o <= 1'b0;
      end else if (sel_fall) begin
        phase_q   <= PH_SHIFT;
        cnt_q     <= '0;
        is_read_q <= 1'b0;
        sdo_oe_o  <= 1'b0;
      end else begin
        if (sck_rise && phase_q == PH_SHIFT) begin
          shreg_q <= {shreg_q[DATA_W-2:0], sdi_s_i};
          cnt_q   <= cnt_q + CNT_W'(1);
          if (cnt_q == C_ADDR_LAST) addr_o <= {shreg_q[ADDR_W-2:0], sdi_s_i};
          if (cnt_q == C_DIR) is_read_q <= sdi_s_i;
          if (cnt_q == C_LOAD && is_read_q) out_sh_q <= rd_data_i;
          if (cnt_q == C_LAST) begin
            phase_q <= PH_DONE;
            if (!is_read_q) begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= addr_o;
              wr_data_o <= {shreg_q[DATA_W-2:0], sdi_s_i};
            end
          end
        end
        if (sck_fall && phase_q != PH_IDLE && is_read_q) begin
          if (cnt_q >= C_DRV_LO && cnt_q <= C_LAST) begin
            sdo_o    <= out_sh_q[DATA_W-1];
            out_sh_q <= out_sh_q << 1;
            sdo_oe_o <= 1'b1;
          end else begin
            sdo_oe_o <= 1'b0;
          end
        end
      end
    end
  end

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    sdo_oe_o |-> (is_read_q && phase_q != PH_IDLE)); // R6
  AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (rst)
    sel_n_s_i |=> !sdo_oe_o); // R7
  AST_WRITE_AT_END: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (phase_q == PH_DONE && !is_read_q)); // R5
  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (sel_n_s_i && phase_q == PH_SHIFT) |=> !wr_en_o); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= C_FRAME); // R8
endmodule

// File: rtl/tw_serial_regs.sv
module tw_serial_regs #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int GAP_CLKS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              sel_n_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  input  logic              dev_we_i,
  input  logic [ADDR_W-1:0] dev_waddr_i,
  input  logic [DATA_W-1:0] dev_wdata_i,
  input  logic [ADDR_W-1:0] dev_raddr_i,
  output logic [DATA_W-1:0] dev_rdata_o
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_waddr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;

  // The data pin uses the same depth as the clock and select, so all three stay aligned.
  tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sdio_i, sel_n_i, sck_i}),
    .q_o (pins_s)
  );

  tw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_CLKS(GAP_CLKS)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .sck_s_i   (pins_s[0]),
    .sel_n_s_i (pins_s[1]),
    .sdi_s_i   (pins_s[2]),
    .rd_data_i (bus_rdata),
    .addr_o    (bus_addr),
    .wr_en_o   (bus_we),
    .wr_addr_o (bus_waddr),
    .wr_data_o (bus_wdata),
    .sdo_o     (sdio_o),
    .sdo_oe_o  (sdio_oe_o)
  );

  tw_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .a_we_i    (bus_we),
    .a_waddr_i (bus_waddr),
    .a_wdata_i (bus_wdata),
    .b_we_i    (dev_we_i),
    .b_waddr_i (dev_waddr_i),
    .b_wdata_i (dev_wdata_i),
    .ra_addr_i (bus_addr),
    .ra_data_o (bus_rdata),
    .rb_addr_i (dev_raddr_i),
    .rb_data_o (dev_rdata_o)
  );
endmodule

// File: tb/tb_tw_serial_regs.sv
module tb_tw_serial_regs;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       sck = 1'b0, sel_n = 1'b1, mst_oe = 1'b0, mst_bit = 1'b0;
  logic       dev_we = 1'b0;
  logic [3:0] dev_waddr = '0, dev_raddr = '0;
  logic [7:0] dev_wdata = '0;
  logic       sdio_o, sdio_oe;
  logic [7:0] dev_rdata;
  wire        line = sdio_oe ? sdio_o : (mst_oe ? mst_bit : 1'b1);

  tw_serial_regs dut (
    .clk(clk), .rst(rst), .sck_i(sck), .sel_n_i(sel_n), .sdio_i(line),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .dev_we_i(dev_we),
    .dev_waddr_i(dev_waddr), .dev_wdata_i(dev_wdata),
    .dev_raddr_i(dev_raddr), .dev_rdata_o(dev_rdata)
  );

  int         n_cmp = 0, n_bad = 0;
  bit         reported = 0;
  logic [7:0] exp_q[$];

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  // Driver: pushes the expected byte of every complete read frame onto the scoreboard.
  task automatic bus_frame(input logic [3:0] a, input logic rd, input logic [7:0] wd, input int nclk);
    @(negedge clk);
    sel_n = 1'b0;
    half_wait(); half_wait();
    if (rd && nclk >= 16) exp_q.push_back(wd);
    for (int i = 0; i < nclk; i++) begin
      if (i < 4)       {mst_oe, mst_bit} = {1'b1, a[3-i]};
      else if (i == 4) {mst_oe, mst_bit} = {1'b1, rd};
      else if (i < 8)  {mst_oe, mst_bit} = 2'b11;
      else if (i < 16) {mst_oe, mst_bit} = {~rd, wd[15-i]};
      else             {mst_oe, mst_bit} = {~rd, 1'b1};
      half_wait();
      sck = 1'b1;
      half_wait();
      sck = 1'b0;
    end
    half_wait();
    mst_oe = 1'b0;
    sel_n  = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic dev_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    dev_we = 1'b1; dev_waddr = a; dev_wdata = d;
    @(negedge clk);
    dev_we = 1'b0;
  endtask

  task automatic dev_read_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    dev_raddr = a;
    @(negedge clk);
    check(tag, dev_rdata, exp);
  endtask

  // Monitor: follows each frame on the wire and compares read bytes with the scoreboard.
  int         mcnt = 0;
  logic       mrd = 1'b0;
  logic [7:0] mbyte = '0;
  always @(posedge sck or negedge sel_n) begin
    if (!sck) begin
      mcnt = 0; mrd = 1'b0; mbyte = '0;
    end else if (!sel_n) begin
      if (mcnt == 4) mrd = line;
      if (mrd && mcnt >= 8 && mcnt <= 15) begin
        check("R6 enable during read data", sdio_oe, 1);
        mbyte = {mbyte[6:0], line};
      end else if (mcnt >= 5 && mcnt <= 7) begin
        check("R4 wire not driven in gap", sdio_oe, 0);
      end else if (mcnt >= 16) begin
        check("R8 wire not driven after frame", sdio_oe, 0);
      end else begin
        check("R3 wire not driven outside read data", sdio_oe, 0);
      end
      mcnt++;
      if (mcnt == 16 && mrd) begin
        if (exp_q.size() == 0) check("R6 unexpected read byte", mbyte, -1);
        else check("R6 read byte", mbyte, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 enable after reset", sdio_oe, 0);
    check("R1 data out after reset", sdio_o, 0);
    check("R1 device read after reset", dev_rdata, 0);

    bus_frame(4'd3, 1'b0, 8'hA5, 16);
    dev_read_chk("R5 bus write stored", 4'd3, 8'hA5);
    bus_frame(4'd12, 1'b0, 8'h3C, 16);
    dev_read_chk("R2 index 12 written", 4'd12, 8'h3C);
    dev_read_chk("R2 index 3 untouched", 4'd3, 8'hA5);

    bus_frame(4'd3, 1'b1, 8'hA5, 16);

    dev_write(4'd7, 8'h81);
    dev_read_chk("R9 device write and read", 4'd7, 8'h81);
    bus_frame(4'd7, 1'b1, 8'h81, 16); // R10
    dev_write(4'd0, 8'h00);
    bus_frame(4'd0, 1'b1, 8'h00, 16);
    dev_write(4'd15, 8'hFF);
    bus_frame(4'd15, 1'b1, 8'hFF, 16);
    bus_frame(4'd9, 1'b0, 8'h96, 16);
    bus_frame(4'd9, 1'b1, 8'h96, 16);

    dev_write(4'd4, 8'h3C);
    bus_frame(4'd4, 1'b1, 8'h3C, 16);
    dev_read_chk("R3 read frame leaves register", 4'd4, 8'h3C);

    dev_write(4'd5, 8'h11);
    bus_frame(4'd5, 1'b0, 8'hEE, 15);
    dev_read_chk("R7 abort at clock 15", 4'd5, 8'h11);
    bus_frame(4'd5, 1'b0, 8'hEE, 9);
    dev_read_chk("R7 abort at clock 9", 4'd5, 8'h11);
    bus_frame(4'd5, 1'b1, 8'h11, 12);
    check("R7 enable low after aborted read", sdio_oe, 0);

    bus_frame(4'd9, 1'b0, 8'h00, 16);
    dev_read_chk("R4 gap ones kept out of data", 4'd9, 8'h00);

    dev_write(4'd10, 8'h22);
    bus_frame(4'd2, 1'b0, 8'h5A, 20);
    dev_read_chk("R8 write with extra clocks", 4'd2, 8'h5A);
    dev_read_chk("R8 other register untouched", 4'd10, 8'h22);
    bus_frame(4'd2, 1'b1, 8'h5A, 20);

    check("R6 scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule